// File: doc/BRIEF.md
# Accumulator Readout Converter

This block turns a wide multiply-accumulate accumulator value into one general register word. It is used when an instruction moves an accumulator into a data register. The caller picks one of three readout styles: fractional, signed integer or unsigned integer. In fractional mode three control bits shape the result. `su` asks for a 16-bit result rounded half-to-even. `rt` turns on half-to-even rounding of the 32-bit result. `omc` clamps a result that does not fit.

All datapath logic is combinational. A parameter adds one output register, so the block can sit on either side of a pipeline boundary. The block only reads the accumulator. It never changes the accumulator or any status bits.

Top module: `acc_readout`

## Requirements
- R1: With `mode`=2'b00 and `su`=1, the result is accumulator bits [39:24] zero-extended to 32 bits. Those 16 bits are rounded half-to-even using bits [23:0], where the halfway point is 0x800000. Result bits [31:16] are always zero.
- R2: With `mode`=2'b00, `su`=0 and `rt`=1, the result is the accumulator shifted right by 8. That value is rounded half-to-even using bits [7:0], where the halfway point is 0x80.
- R3: With `mode`=2'b00, `su`=0 and `rt`=0, the result is the accumulator shifted right by 8 and truncated, with no rounding.
- R4: With `mode`=2'b00, `su`=1 and `omc`=1, a rounded 16-bit value that carries out of 16 bits gives 0x7FFF when accumulator bit 63 is 0 and 0x8000 when it is 1. With `omc`=0 the carry is dropped and the low 16 bits are kept.
- R5: With `mode`=2'b00, `su`=0 and `omc`=1, a shifted or rounded value wider than 32 bits gives 0x7FFFFFFF when accumulator bit 63 is 0 and 0x00000000 when it is 1. With `omc`=0 the low 32 bits are kept.
- R6: With `mode`=2'b01 (signed integer), an accumulator that equals the sign extension of its low 32 bits is passed through. Any other value gives 0x7FFFFFFF when bit 63 is 0 and 0x80000000 when bit 63 is 1.
- R7: With `mode`=2'b10 or 2'b11 (unsigned integer), an accumulator whose upper 32 bits are zero passes its low 32 bits through. Any other value gives 0xFFFFFFFF.
- R8: With OUT_REG=1, `result` is 0 during reset. It shows the conversion of the inputs sampled at a rising edge, just after that edge, and holds between edges. With OUT_REG=0, `result` follows the inputs in the same cycle.
- R9: In both integer modes, the `su`, `rt` and `omc` inputs have no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_in | input | ACC_W | Accumulator value to convert |
| mode | input | 2 | 00 fractional, 01 signed integer, 1x unsigned integer |
| su | input | 1 | Fractional 16-bit result with rounding |
| rt | input | 1 | Rounding of the 32-bit fractional result |
| omc | input | 1 | Saturate on overflow |
| result | output | DATA_W | Converted register word |

## Verification
The bench builds two copies at the default widths (64-bit accumulator, 32-bit word, 8 guard bits). One copy has OUT_REG=1 and the other has OUT_REG=0, so both the registered variant and the pass-through variant are covered and the one-cycle offset between them can be compared directly. At these widths the directed vectors can hit exact halfway remainders with both even and odd values. They also reach the carry out of 0xFFFF in the 16-bit lane, the 56-bit value crossing 2^32 in the 32-bit lane, and both signed boundaries around ±2^31. Random accumulators, modes and control bits then cover the rest of the input space.

// File: rtl/acc_rd_pkg.sv
`timescale 1ns/1ps
package acc_rd_pkg;
   typedef enum logic [1:0] {
      RD_FRAC  = 2'b00,
      RD_SINT  = 2'b01,
      RD_UINT  = 2'b10,
      RD_UINT2 = 2'b11
   } rd_mode_e;
endpackage

// File: rtl/acc_rd_round.sv
`timescale 1ns/1ps
// Round-half-to-even of VAL_W bits using a REM_W-bit remainder; carry kept.
module acc_rd_round #(
   parameter int VAL_W = 16,
   parameter int REM_W = 24
) (
   input  logic [VAL_W-1:0] val_i,
   input  logic [REM_W-1:0] rem_i,
   input  logic             round_en_i,
   output logic [VAL_W:0]   val_o
);
   localparam logic [REM_W-1:0] HALF = {1'b1, {(REM_W-1){1'b0}}};

   if (VAL_W < 1 || REM_W < 1) begin : g_bad_width
      $error("acc_rd_round: widths must be positive");
   end

   logic above_half;
   logic at_half;
   logic bump;

   always_comb begin
      above_half = (rem_i > HALF);
      at_half    = (rem_i == HALF);
      bump       = round_en_i && (above_half || (at_half && val_i[0]));
      val_o      = {1'b0, val_i} + {{VAL_W{1'b0}}, bump};
   end
endmodule

// File: rtl/acc_rd_sat.sv
`timescale 1ns/1ps
// Clamp an IN_W-bit unsigned value into OUT_W bits; negative limit variant chosen by parameter.
module acc_rd_sat #(
   parameter int IN_W       = 17,
   parameter int OUT_W      = 16,
   parameter bit NEG_TO_MIN = 1'b1
) (
   input  logic [IN_W-1:0]  val_i,
   input  logic             sat_en_i,
   input  logic             neg_i,
   output logic [OUT_W-1:0] val_o
);
   if (IN_W <= OUT_W) begin : g_bad_width
      $error("acc_rd_sat: IN_W must exceed OUT_W");
   end

   localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};

   logic [OUT_W-1:0] neg_lim;
   logic             ovf;

   if (NEG_TO_MIN) begin : g_neg_min
      assign neg_lim = {1'b1, {(OUT_W-1){1'b0}}};
   end else begin : g_neg_zero
      assign neg_lim = '0;
   end

   always_comb begin
      ovf = |val_i[IN_W-1:OUT_W];
      if (sat_en_i && ovf) begin
         val_o = neg_i ? neg_lim : POS_LIM;
      end else begin
         val_o = val_i[OUT_W-1:0];
      end
   end
endmodule

// File: rtl/acc_rd_int.sv
`timescale 1ns/1ps
// Integer readout: signed or unsigned clamp of the accumulator into DATA_W bits.
module acc_rd_int #(
   parameter int ACC_W  = 64,
   parameter int DATA_W = 32
) (
   input  logic [ACC_W-1:0]  acc_i,
   input  logic              signed_i,
   output logic [DATA_W-1:0] val_o
);
   if (ACC_W <= DATA_W) begin : g_bad_width
      $error("acc_rd_int: ACC_W must exceed DATA_W");
   end

   localparam logic [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

   logic [ACC_W-DATA_W:0]   sgn_field;
   logic [ACC_W-DATA_W-1:0] hi_word;
   logic                    s_fits;
   logic                    u_fits;

   always_comb begin
      sgn_field = acc_i[ACC_W-1:DATA_W-1];
      hi_word   = acc_i[ACC_W-1:DATA_W];
      s_fits    = (&sgn_field) || !(|sgn_field);
      u_fits    = !(|hi_word);
      if (signed_i) begin
         val_o = s_fits ? acc_i[DATA_W-1:0] : (acc_i[ACC_W-1] ? S_MIN : S_MAX);
      end else begin
         val_o = u_fits ? acc_i[DATA_W-1:0] : {DATA_W{1'b1}};
      end
   end
endmodule

// File: rtl/acc_readout.sv
`timescale 1ns/1ps
module acc_readout #(
   parameter int ACC_W   = 64,
   parameter int DATA_W  = 32,
   parameter int GUARD_W = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ACC_W-1:0]  acc_in,
   input  logic [1:0]        mode,
   input  logic              su,
   input  logic              rt,
   input  logic              omc,
   output logic [DATA_W-1:0] result
);
   import acc_rd_pkg::*;

   localparam int HALF_W   = DATA_W / 2;
   localparam int SU_REM_W = GUARD_W + HALF_W;
   localparam int WIDE_W   = ACC_W - GUARD_W;

   if (DATA_W % 2 != 0) begin : g_bad_data
      $error("acc_readout: DATA_W must be even");
   end
   if (GUARD_W < 1) begin : g_bad_guard
      $error("acc_readout: GUARD_W must be at least 1");
   end
   if (SU_REM_W + HALF_W > ACC_W || WIDE_W <= DATA_W || ACC_W < 2 * DATA_W) begin : g_bad_acc
      $error("acc_readout: ACC_W too narrow for the chosen fields");
   end

   // 16-bit fractional lane: always rounds
   logic [HALF_W:0]   half_rnd;
   logic [HALF_W-1:0] half_val;

   acc_rd_round #(.VAL_W(HALF_W), .REM_W(SU_REM_W)) u_rnd_half (
      .val_i      (acc_in[SU_REM_W +: HALF_W]),
      .rem_i      (acc_in[SU_REM_W-1:0]),
      .round_en_i (1'b1),
      .val_o      (half_rnd)
   );

   acc_rd_sat #(.IN_W(HALF_W + 1), .OUT_W(HALF_W), .NEG_TO_MIN(1'b1)) u_sat_half (
      .val_i    (half_rnd),
      .sat_en_i (omc),
      .neg_i    (acc_in[ACC_W-1]),
      .val_o    (half_val)
   );

   // 32-bit fractional lane: rounds only with rt
   logic [WIDE_W:0]   wide_rnd;
   logic [DATA_W-1:0] wide_val;

   acc_rd_round #(.VAL_W(WIDE_W), .REM_W(GUARD_W)) u_rnd_wide (
      .val_i      (acc_in[ACC_W-1:GUARD_W]),
      .rem_i      (acc_in[GUARD_W-1:0]),
      .round_en_i (rt),
      .val_o      (wide_rnd)
   );

   acc_rd_sat #(.IN_W(WIDE_W + 1), .OUT_W(DATA_W), .NEG_TO_MIN(1'b0)) u_sat_wide (
      .val_i    (wide_rnd),
      .sat_en_i (omc),
      .neg_i    (acc_in[ACC_W-1]),
      .val_o    (wide_val)
   );

   // integer lane
   logic [DATA_W-1:0] int_val;

   acc_rd_int #(.ACC_W(ACC_W), .DATA_W(DATA_W)) u_int (
      .acc_i    (acc_in),
      .signed_i (mode == RD_SINT),
      .val_o    (int_val)
   );

   logic [DATA_W-1:0] sel_val;

   always_comb begin
      unique case (rd_mode_e'(mode))
         RD_FRAC: sel_val = su ? {{(DATA_W-HALF_W){1'b0}}, half_val} : wide_val;
         default: sel_val = int_val;
      endcase
   end

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result <= '0;
         end else begin
            result <= sel_val;
         end
      end
   end else begin : g_out_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign result = sel_val;
   end
endmodule

// File: rtl/acc_readout_chk.sv
`timescale 1ns/1ps
module acc_readout_chk #(
   parameter int ACC_W   = 64,
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ACC_W-1:0]  acc_in,
   input logic [1:0]        mode,
   input logic              su,
   input logic              rt,
   input logic              omc,
   input logic [DATA_W-1:0] result
);
   localparam int HALF_W = DATA_W / 2;

   logic [ACC_W-1:0] p_acc;
   logic [1:0]       p_mode;
   logic             p_su;
   logic             p_ok;

   if (OUT_REG) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_acc  <= '0;
            p_mode <= '0;
            p_su   <= 1'b0;
            p_ok   <= 1'b0;
         end else begin
            p_acc  <= acc_in;
            p_mode <= mode;
            p_su   <= su;
            p_ok   <= 1'b1;
         end
      end
   end else begin : g_now
      assign p_acc  = acc_in;
      assign p_mode = mode;
      assign p_su   = su;
      assign p_ok   = 1'b1;
   end

   logic unused_ctl;
   assign unused_ctl = rt ^ omc;

   logic [ACC_W-DATA_W-1:0] p_hi;
   logic [ACC_W-DATA_W:0]   p_sf;
   assign p_hi = p_acc[ACC_W-1:DATA_W];
   assign p_sf = p_acc[ACC_W-1:DATA_W-1];

   // R1
   a_r1_half_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (p_ok && p_mode == 2'b00 && p_su) |-> (result[DATA_W-1:HALF_W] == '0));

   // R7
   a_r7_uint_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (p_ok && p_mode[1] && p_hi == '0) |-> (result == p_acc[DATA_W-1:0]));

   a_r7_uint_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (p_ok && p_mode[1] && p_hi != '0) |-> (result == {DATA_W{1'b1}}));

   // R6
   a_r6_sint_clamp_pos: assert property (@(posedge clk) disable iff (!rst_n)
      (p_ok && p_mode == 2'b01 && !p_acc[ACC_W-1] && p_sf != '0)
      |-> (result == {1'b0, {(DATA_W-1){1'b1}}}));

   a_r6_sint_clamp_neg: assert property (@(posedge clk) disable iff (!rst_n)
      (p_ok && p_mode == 2'b01 && p_acc[ACC_W-1] && !(&p_sf))
      |-> (result == {1'b1, {(DATA_W-1){1'b0}}}));

   a_r6_sint_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (p_ok && p_mode == 2'b01 && ((&p_sf) || p_sf == '0))
      |-> (result == p_acc[DATA_W-1:0]));
endmodule

bind acc_readout acc_readout_chk #(
   .ACC_W   (ACC_W),
   .DATA_W  (DATA_W),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .acc_in (acc_in),
   .mode   (mode),
   .su     (su),
   .rt     (rt),
   .omc    (omc),
   .result (result)
);

// File: tb/acc_readout_test.sv
`timescale 1ns/1ps
module acc_readout_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] acc_in = '0;
   logic [1:0]  mode = 2'b00;
   logic        su = 1'b0;
   logic        rt = 1'b0;
   logic        omc = 1'b0;
   logic [31:0] res_r;
   logic [31:0] res_c;

   int total = 0;
   int bad = 0;
   logic [31:0] last_exp = '0;

   always #2.5 clk = ~clk;

   acc_readout #(.OUT_REG(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .mode(mode),
      .su(su), .rt(rt), .omc(omc), .result(res_r)
   );

   acc_readout #(.OUT_REG(1'b0)) uut_comb (
      .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .mode(mode),
      .su(su), .rt(rt), .omc(omc), .result(res_c)
   );

   // behavioural reference from the requirements
   function automatic logic [31:0] ref_out(logic [63:0] a, logic [1:0] m, bit s, bit r, bit o);
      longint sv;
      longint unsigned q, rem, half;
      if (m == 2'b01) begin
         sv = $signed(a);
         if (sv >= -64'sd2147483648 && sv <= 64'sd2147483647) return a[31:0];
         return a[63] ? 32'h8000_0000 : 32'h7FFF_FFFF;
      end
      if (m[1]) return ((a >> 32) == 0) ? a[31:0] : 32'hFFFF_FFFF;
      if (s) begin
         q    = (a >> 24) % 65536;
         rem  = a % (64'd1 << 24);
         half = 64'd1 << 23;
         if (rem > half || (rem == half && q % 2 == 1)) q = q + 1;
         if (o && q > 65535) return a[63] ? 32'h0000_8000 : 32'h0000_7FFF;
         return 32'(q % 65536);
      end
      q   = a >> 8;
      rem = a % 256;
      if (r && (rem > 128 || (rem == 128 && q % 2 == 1))) q = q + 1;
      if (o && q > 64'hFFFF_FFFF) return a[63] ? 32'h0 : 32'h7FFF_FFFF;
      return q[31:0];
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [63:0] a, input logic [1:0] m, input bit s, input bit r,
                       input bit o, input logic [31:0] e, input string tag);
      @(negedge clk);
      acc_in = a; mode = m; su = s; rt = r; omc = o;
      #1;
      chk({tag, " comb"}, res_c, e);
      chk("R8 hold before edge", res_r, last_exp);
      @(posedge clk);
      #1;
      chk({tag, " reg"}, res_r, e);
      last_exp = e;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R8 reset value", res_r, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;

      // R1 16-bit half-even rounding
      step(64'h0000_0012_3440_0000, 2'b00, 1, 0, 0, 32'h0000_1234, "R1 below half");
      step(64'h0000_0012_3480_0000, 2'b00, 1, 0, 0, 32'h0000_1234, "R1 half even");
      step(64'h0000_0012_3580_0000, 2'b00, 1, 0, 0, 32'h0000_1236, "R1 half odd");
      step(64'h0000_0012_3480_0001, 2'b00, 1, 0, 0, 32'h0000_1235, "R1 above half");
      step(64'hABCD_EF12_3440_0000, 2'b00, 1, 0, 1, 32'h0000_1234, "R1 upper bits ignored");
      // R4 16-bit carry out
      step(64'h0000_00FF_FF90_0000, 2'b00, 1, 0, 1, 32'h0000_7FFF, "R4 clamp pos");
      step(64'h8000_00FF_FF90_0000, 2'b00, 1, 0, 1, 32'h0000_8000, "R4 clamp neg");
      step(64'h0000_00FF_FF90_0000, 2'b00, 1, 0, 0, 32'h0000_0000, "R4 wrap no omc");
      // R2 32-bit half-even rounding
      step(64'h0000_0000_1234_5680, 2'b00, 0, 1, 0, 32'h0012_3456, "R2 half even");
      step(64'h0000_0000_1234_5780, 2'b00, 0, 1, 0, 32'h0012_3458, "R2 half odd");
      step(64'h0000_0000_1234_5681, 2'b00, 0, 1, 0, 32'h0012_3457, "R2 above half");
      // R3 truncation
      step(64'h0000_0000_1234_56FF, 2'b00, 0, 0, 0, 32'h0012_3456, "R3 truncate");
      // R5 32-bit overflow
      step(64'h0000_00FF_FFFF_FFFF, 2'b00, 0, 1, 1, 32'h7FFF_FFFF, "R5 round carry clamp");
      step(64'h0000_00FF_FFFF_FFFF, 2'b00, 0, 1, 0, 32'h0000_0000, "R5 round carry wrap");
      step(64'h0000_0100_0000_0000, 2'b00, 0, 0, 1, 32'h7FFF_FFFF, "R5 clamp pos");
      step(64'hFFFF_FFFF_FFFF_FF00, 2'b00, 0, 0, 1, 32'h0000_0000, "R5 clamp neg");
      step(64'hFFFF_FFFF_FFFF_FF00, 2'b00, 0, 0, 0, 32'hFFFF_FFFF, "R5 low word no omc");
      // R6 signed integer
      step(64'h0000_0000_7FFF_FFFF, 2'b01, 0, 0, 0, 32'h7FFF_FFFF, "R6 max pass");
      step(64'h0000_0000_8000_0000, 2'b01, 0, 0, 0, 32'h7FFF_FFFF, "R6 clamp pos");
      step(64'hFFFF_FFFF_8000_0000, 2'b01, 0, 0, 0, 32'h8000_0000, "R6 min pass");
      step(64'hFFFF_FFFF_7FFF_FFFF, 2'b01, 0, 0, 0, 32'h8000_0000, "R6 clamp neg");
      step(64'hFFFF_FFFF_FFFF_FFFE, 2'b01, 0, 0, 0, 32'hFFFF_FFFE, "R6 small neg");
      // R9 controls ignored in integer modes
      step(64'h0000_0000_8000_0000, 2'b01, 1, 1, 1, 32'h7FFF_FFFF, "R9 signed controls");
      step(64'h0000_0012_3458_0000, 2'b01, 1, 1, 0, 32'h7FFF_FFFF, "R9 signed su");
      step(64'h0000_0000_0000_0001, 2'b11, 1, 1, 1, 32'h0000_0001, "R9 unsigned controls");
      // R7 unsigned integer
      step(64'h0000_0000_DEAD_BEEF, 2'b10, 0, 0, 0, 32'hDEAD_BEEF, "R7 pass");
      step(64'h0000_0001_0000_0000, 2'b10, 0, 0, 0, 32'hFFFF_FFFF, "R7 clamp");
      step(64'h8000_0000_0000_0001, 2'b11, 0, 0, 0, 32'hFFFF_FFFF, "R7 alt code clamp");

      // random sweep against the reference
      for (int i = 0; i < 400; i++) begin
         logic [63:0] a;
         logic [1:0]  m;
         bit s, r, o;
         a = {$urandom, $urandom};
         case (i % 4)
            1: a[63:40] = {24{a[63]}};
            2: a[23:0]  = 24'h80_0000;
            3: a[7:0]   = 8'h80;
            default: ;
         endcase
         m = 2'($urandom);
         s = 1'($urandom);
         r = 1'($urandom);
         o = 1'($urandom);
         step(a, m, s, r, o, ref_out(a, m, s, r, o), "R1-R9 random sweep");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule